// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is a host-side serial controller for a 16-bit differential successive-approximation converter with a three-wire serial interface. It drives the converter's active-low chip select and its serial clock, and it takes in the converter's serial data line. Each result is returned on a parallel port as a signed two's-complement word, together with a one-cycle valid strobe. Every conversion frame has the same shape. Chip select falls and the clock then runs through exactly 20 periods. The line stays undriven until the second falling clock edge. That edge starts a null bit, and sixteen data bits follow it, most significant bit first. Chip select is then raised, and this also puts the converter into power-down.

Frames start in one of two ways. In single-shot mode, a one-cycle start pulse requests one frame. In continuous mode, a new frame begins as soon as the chip-select-high interval has elapsed. That interval is programmable but never shorter than the acquisition minimum. The serial clock half period is a divider setting in system clocks. It is clamped to the range that keeps the serial clock between 1 MHz and 5 MHz, and it is latched when a frame starts.

Top module: `sar_adc_rdout`

## Requirements
- R1: While reset is applied and after it is released, `adc_cs_n` is 1, `adc_sclk` is 1 and `res_vld` is 0 until a frame is started.
- R2: While `adc_cs_n` is 1, `adc_sclk` is 1. Each frame holds `adc_cs_n` at 0 for exactly 20 falling edges of `adc_sclk`, and the first falling edge comes one half period after `adc_cs_n` falls.
- R3: The controller samples `adc_sdo` on rising `adc_sclk` edges 3 to 18 of a frame, and the first of these samples becomes the most significant result bit. Values present before the second falling edge, or during the null bit, do not affect the result.
- R4: `res_word` carries the sixteen captured bits as a signed two's-complement value (0x8000 = -32768, 0x7FFF = 32767). `res_vld` is high for exactly one system cycle per frame, while `adc_cs_n` is still 0, in the cycle after the 18th rising `adc_sclk` edge.
- R5: Every high and low phase of `adc_sclk` within a frame lasts exactly H system cycles. H is `sclk_half` clamped to the range [HALF_MIN, HALF_MAX] (defaults 10 and 50), and it is the value held when the frame started.
- R6: Between two frames, `adc_cs_n` stays high for at least max(`gap_len`, ACQ_MIN) system cycles (default ACQ_MIN = 60).
- R7: With `cont_en` = 0, a `start` pulse issued during a frame is ignored. A `start` pulse issued while the interval between frames is still running is held, and it launches exactly one frame once that interval ends.
- R8: With `cont_en` = 1, frames follow one another without any `start` pulse. Each interval between them lasts max(`gap_len`, ACQ_MIN)+1 system cycles, within a tolerance of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Single-shot frame request pulse |
| cont_en | input | 1 | 1 = repeat frames continuously |
| sclk_half | input | 8 | Serial clock half period in system cycles (clamped) |
| gap_len | input | 12 | Chip-select-high interval in system cycles (minimum ACQ_MIN) |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| adc_sdo | input | 1 | Converter serial data output |
| res_word | output | 16 | Signed conversion result |
| res_vld | output | 1 | One-cycle result strobe |

## Verification
A result is due in the system cycle right after the 18th rising serial clock edge of its frame. The data line passes through a two-stage synchronizer, so a bit must be stable for two cycles before that rising edge. The converter model changes its line at a falling edge, a full half period earlier, so this margin is always met. The bench watches the interface on the falling system clock edge. It records how many falling serial edges the frame had reached when the strobe appeared, and whether chip select was low at that moment. It counts the system cycles in every clock phase and in every chip-select-high interval, and it compares these exact counts with the clamped settings. It does not use fixed delays. Whether a start pulse was ignored is judged by counting strobes over a window longer than a full frame plus the interval that follows it.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  localparam int RES_W      = 16;             // result width
  localparam int FRAME_CLKS = 20;             // serial clocks per frame
  localparam int FIRST_BIT  = 3;              // first rising edge carrying data
  localparam int LAST_BIT   = FIRST_BIT + RES_W - 1;
  localparam int BC_W       = $clog2(FRAME_CLKS + 1);

  typedef enum logic {
    ST_GAP   = 1'b0,
    ST_FRAME = 1'b1
  } rd_state_t;
endpackage

// File: rtl/sar_rd_clamp.sv
module sar_rd_clamp #(
  parameter int DIV_W    = 8,
  parameter int IDLE_W   = 12,
  parameter int HALF_MIN = 10,
  parameter int HALF_MAX = 50,
  parameter int ACQ_MIN  = 60
) (
  input  logic [DIV_W-1:0]  half_raw,
  input  logic [IDLE_W-1:0] gap_raw,
  output logic [DIV_W-1:0]  half_eff,
  output logic [IDLE_W-1:0] gap_eff
);
  localparam logic [DIV_W-1:0]  LO_H = DIV_W'(HALF_MIN);
  localparam logic [DIV_W-1:0]  HI_H = DIV_W'(HALF_MAX);
  localparam logic [IDLE_W-1:0] LO_G = IDLE_W'(ACQ_MIN);

  always_comb begin
    if (half_raw < LO_H)      half_eff = LO_H;
    else if (half_raw > HI_H) half_eff = HI_H;
    else                      half_eff = half_raw;
    gap_eff = (gap_raw < LO_G) ? LO_G : gap_raw;
  end
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int IDLE_W   = 12,
  parameter int HALF_MIN = 10,
  parameter int ACQ_MIN  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cont_en,
  input  logic [DIV_W-1:0]  half_eff,
  input  logic [IDLE_W-1:0] gap_eff,
  output logic              cs_n,
  output logic              sclk,
  output logic              cap_en,
  output logic              cap_last
);
  localparam logic [BC_W-1:0] BC_END  = BC_W'(FRAME_CLKS);
  localparam logic [BC_W-1:0] BC_FST  = BC_W'(FIRST_BIT);
  localparam logic [BC_W-1:0] BC_LST  = BC_W'(LAST_BIT);
  localparam int              HOLD_W  = DIV_W + 1;
  localparam int              CSH_W   = IDLE_W + 1;

  rd_state_t         st_q, st_d;
  logic              cs_q, cs_d;
  logic              sclk_q, sclk_d;
  logic              ph_q, ph_d;        // 1 = high phase
  logic [DIV_W-1:0]  hc_q, hc_d;
  logic [DIV_W-1:0]  half_q, half_d;
  logic [BC_W-1:0]   bc_q, bc_d;        // falling edges so far
  logic [IDLE_W-1:0] ic_q, ic_d;
  logic              pend_q, pend_d;
  logic              go;

  always_comb begin
    st_d     = st_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    ph_d     = ph_q;
    hc_d     = hc_q;
    half_d   = half_q;
    bc_d     = bc_q;
    ic_d     = ic_q;
    pend_d   = pend_q;
    cap_en   = 1'b0;
    cap_last = 1'b0;
    go       = 1'b0;
    case (st_q)
      ST_GAP: begin
        if (ic_q < gap_eff) ic_d = ic_q + 1'b1;
        if (start) pend_d = 1'b1;
        go = (ic_q >= gap_eff) && (cont_en || start || pend_q);
        if (go) begin
          st_d   = ST_FRAME;
          cs_d   = 1'b0;
          sclk_d = 1'b1;
          ph_d   = 1'b1;
          hc_d   = '0;
          bc_d   = '0;
          half_d = half_eff;
          pend_d = 1'b0;
        end
      end
      default: begin
        if (hc_q == half_q - 1'b1) begin
          hc_d = '0;
          if (ph_q) begin
            if (bc_q == BC_END) begin
              st_d = ST_GAP;
              cs_d = 1'b1;
              ic_d = '0;
            end else begin
              ph_d   = 1'b0;
              sclk_d = 1'b0;
              bc_d   = bc_q + 1'b1;
            end
          end else begin
            ph_d   = 1'b1;
            sclk_d = 1'b1;
            if (bc_q >= BC_FST && bc_q <= BC_LST) cap_en = 1'b1;
            if (bc_q == BC_LST) cap_last = 1'b1;
          end
        end else begin
          hc_d = hc_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_GAP;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      ph_q   <= 1'b1;
      hc_q   <= '0;
      half_q <= DIV_W'(HALF_MIN);
      bc_q   <= '0;
      ic_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      ph_q   <= ph_d;
      hc_q   <= hc_d;
      half_q <= half_d;
      bc_q   <= bc_d;
      ic_q   <= ic_d;
      pend_q <= pend_d;
    end
  end

  assign cs_n = cs_q;
  assign sclk = sclk_q;

  // Checker state: length of each clock phase and of each chip-select-high run
  logic              sclk_prev_q;
  logic [HOLD_W-1:0] hold_q;
  logic [CSH_W-1:0]  csh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b1;
      hold_q      <= '0;
      csh_q       <= '0;
    end else begin
      sclk_prev_q <= sclk_q;
      if (sclk_q != sclk_prev_q)  hold_q <= HOLD_W'(1);
      else if (hold_q != '1)      hold_q <= hold_q + 1'b1;
      if (!cs_q)                  csh_q  <= '0;
      else if (csh_q != '1)       csh_q  <= csh_q + 1'b1;
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_q);

  assert_half_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_q && (sclk_q != sclk_prev_q)) |-> (hold_q >= HOLD_W'(HALF_MIN)));

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (csh_q >= CSH_W'(ACQ_MIN)));

  assert_cap_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (!cs_q && !sclk_q));
endmodule

// File: rtl/sar_rd_shift.sv
module sar_rd_shift
  import sar_rd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sdo,
  input  logic                    cap_en,
  input  logic                    cap_last,
  output logic signed [RES_W-1:0] word,
  output logic                    vld
);
  logic [RES_W-1:0] sh_q, sh_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             vld_q, vld_d;

  always_comb begin
    sh_d  = sh_q;
    res_d = res_q;
    vld_d = 1'b0;
    if (cap_en) sh_d = {sh_q[RES_W-2:0], sdo};
    if (cap_last) begin
      res_d = {sh_q[RES_W-2:0], sdo};
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign word = $signed(res_q);
  assign vld  = vld_q;

  assert_vld_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  assert_vld_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !cs_n);

  assert_res_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(res_q));
endmodule

// File: rtl/sar_adc_rdout.sv
module sar_adc_rdout
  import sar_rd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int IDLE_W   = 12,
  parameter int HALF_MIN = 10,
  parameter int HALF_MAX = 50,
  parameter int ACQ_MIN  = 60
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    cont_en,
  input  logic [DIV_W-1:0]        sclk_half,
  input  logic [IDLE_W-1:0]       gap_len,
  output logic                    adc_cs_n,
  output logic                    adc_sclk,
  input  logic                    adc_sdo,
  output logic signed [RES_W-1:0] res_word,
  output logic                    res_vld
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [1:0]        sdo_sync_q;
  logic [DIV_W-1:0]  half_eff;
  logic [IDLE_W-1:0] gap_eff;
  logic              cap_en, cap_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) sdo_sync_q <= 2'b00;
    else          sdo_sync_q <= {sdo_sync_q[0], adc_sdo};
  end

  sar_rd_clamp #(
    .DIV_W(DIV_W), .IDLE_W(IDLE_W), .HALF_MIN(HALF_MIN),
    .HALF_MAX(HALF_MAX), .ACQ_MIN(ACQ_MIN)
  ) u_clamp (
    .half_raw (sclk_half),
    .gap_raw  (gap_len),
    .half_eff (half_eff),
    .gap_eff  (gap_eff)
  );

  sar_rd_seq #(
    .DIV_W(DIV_W), .IDLE_W(IDLE_W), .HALF_MIN(HALF_MIN), .ACQ_MIN(ACQ_MIN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .cont_en  (cont_en),
    .half_eff (half_eff),
    .gap_eff  (gap_eff),
    .cs_n     (adc_cs_n),
    .sclk     (adc_sclk),
    .cap_en   (cap_en),
    .cap_last (cap_last)
  );

  sar_rd_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cs_n     (adc_cs_n),
    .sdo      (sdo_sync_q[1]),
    .cap_en   (cap_en),
    .cap_last (cap_last),
    .word     (res_word),
    .vld      (res_vld)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> (adc_cs_n && adc_sclk && !res_vld));
endmodule

// File: tb/tb_sar_adc_rdout.sv
module tb_sar_adc_rdout;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, cont_en;
  logic [7:0]  sclk_half;
  logic [11:0] gap_len;
  logic        adc_cs_n, adc_sclk, adc_sdo;
  logic signed [15:0] res_word;
  logic        res_vld;

  int checks, errors;

  sar_adc_rdout dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_en(cont_en),
    .sclk_half(sclk_half), .gap_len(gap_len),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
    .res_word(res_word), .res_vld(res_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- converter model and monitor ----------------
  logic [15:0] words [8];
  logic        clr_stats;
  int fidx, falls, last_falls, run, minh, maxh, gap_cnt, last_gap;
  int nvld, vld_falls, vld_cs, vld_wide, nfr;
  logic signed [15:0] res_log [8];
  logic cs_prev, sclk_prev, vld_prev;

  initial begin
    fidx = 0; falls = 0; last_falls = 0; run = 0; minh = 1000; maxh = 0;
    gap_cnt = 0; last_gap = 0; nvld = 0; vld_falls = 0; vld_cs = 1;
    vld_wide = 0; nfr = 0; cs_prev = 1'b1; sclk_prev = 1'b1; vld_prev = 1'b0;
    adc_sdo = 1'b1;
  end

  always @(negedge clk) begin
    if (clr_stats) begin
      minh = 1000; maxh = 0; vld_wide = 0;
    end
    if (adc_cs_n) gap_cnt++;
    if (cs_prev && !adc_cs_n) begin
      last_gap = gap_cnt; falls = 0; run = 0;
    end
    if (!cs_prev && adc_cs_n) begin
      last_falls = falls; fidx = (fidx + 1) % 8; nfr++; gap_cnt = 1;
      adc_sdo = 1'b1;
    end
    if (!adc_cs_n && adc_sclk != sclk_prev) begin
      if (falls >= 1) begin
        if (run < minh) minh = run;
        if (run > maxh) maxh = run;
      end
      run = 1;
      if (!adc_sclk) begin
        falls++;
        if (falls == 2)                    adc_sdo = 1'b0;
        else if (falls >= 3 && falls <= 18) adc_sdo = words[fidx][18-falls];
        else                               adc_sdo = 1'b1;
      end
    end else begin
      run++;
    end
    if (res_vld) begin
      res_log[nvld % 8] = res_word;
      nvld++; vld_falls = falls; vld_cs = adc_cs_n;
      if (vld_prev) vld_wide++;
    end
    cs_prev = adc_cs_n; sclk_prev = adc_sclk; vld_prev = res_vld;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic clear_stats();
    @(negedge clk); clr_stats = 1'b1;
    @(negedge clk); clr_stats = 1'b0;
  endtask

  task automatic wait_vld(input int target);
    for (int i = 0; i < 20000 && nvld < target; i++) @(negedge clk);
  endtask

  task automatic wait_cs_high();
    for (int i = 0; i < 20000 && !adc_cs_n; i++) @(negedge clk);
    wait_cycles(2);
  endtask

  function automatic int clamp_h(input int d);
    return (d < 10) ? 10 : (d > 50) ? 50 : d;
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; cont_en = 1'b0; sclk_half = 8'd20;
    gap_len = 12'd0; clr_stats = 1'b0;
    wait_cycles(5);
    check(adc_cs_n == 1'b1, "R1 cs_n in reset", adc_cs_n, 1);
    check(adc_sclk == 1'b1, "R1 sclk in reset", adc_sclk, 1);
    check(res_vld == 1'b0,  "R1 vld in reset", res_vld, 0);
    rst_n = 1'b1;
    wait_cycles(100);
    check(adc_cs_n == 1'b1 && adc_sclk == 1'b1 && nvld == 0,
          "R1 idle after reset", nvld, 0);
  endtask

  task automatic t_single(input logic [15:0] w, input int div);
    int base, hexp;
    for (int i = 0; i < 8; i++) words[i] = w;
    sclk_half = 8'(div); cont_en = 1'b0; gap_len = 12'd0;
    hexp = clamp_h(div);
    clear_stats();
    base = nvld;
    pulse_start();
    wait_vld(base + 1);
    wait_cs_high();
    check(nvld == base + 1, "R4 one strobe", nvld - base, 1);
    check(int'(res_log[base % 8]) == int'($signed(w)), "R3 R4 signed word",
          int'(res_log[base % 8]), int'($signed(w)));
    check(vld_falls == 18 && vld_cs == 0, "R4 strobe timing", vld_falls, 18);
    check(vld_wide == 0, "R4 strobe width", vld_wide, 0);
    check(last_falls == 20, "R2 falls per frame", last_falls, 20);
    check(minh == hexp && maxh == hexp, "R5 half period min", minh, hexp);
    check(maxh == hexp, "R5 half period max", maxh, hexp);
  endtask

  task automatic t_ignore_and_pend();
    int base;
    for (int i = 0; i < 8; i++) words[i] = 16'h3C5A;
    sclk_half = 8'd20; cont_en = 1'b0; gap_len = 12'd0;
    clear_stats();
    base = nvld;
    pulse_start();
    for (int i = 0; i < 5000 && !(falls == 8 && !adc_cs_n); i++) @(negedge clk);
    pulse_start();                 // during the frame: ignored (R7)
    sclk_half = 8'd40;             // mid-frame change: not applied (R5)
    wait_vld(base + 1);
    wait_cs_high();
    check(minh == 20 && maxh == 20, "R5 setting latched at frame start", maxh, 20);
    wait_cycles(3000);
    check(nvld == base + 1, "R7 start in frame ignored", nvld - base, 1);
    check(adc_cs_n == 1'b1, "R7 no extra frame", adc_cs_n, 1);
    // pending start issued during the gap interval
    sclk_half = 8'd10;
    pulse_start();
    wait_cycles(1);
    wait_vld(base + 2);
    wait_cs_high();
    check(nvld == base + 2, "R7 start in gap held", nvld - base, 2);
    check(last_gap >= 60, "R6 gap floor", last_gap, 60);
    check(int'(res_log[(base + 1) % 8]) == int'(16'sh3C5A), "R3 pend word",
          int'(res_log[(base + 1) % 8]), int'(16'sh3C5A));
    wait_cycles(3000);
    check(nvld == base + 2, "R7 single frame from pend", nvld - base, 2);
  endtask

  task automatic t_continuous(input int gap);
    int base, f0, geff, g;
    logic [15:0] pat [4];
    pat[0] = 16'h0001; pat[1] = 16'hFFFF; pat[2] = 16'h4000; pat[3] = 16'hC001;
    geff = (gap < 60) ? 60 : gap;
    f0 = fidx;
    for (int i = 0; i < 8; i++) words[(f0 + i) % 8] = pat[i % 4];
    sclk_half = 8'd12; gap_len = 12'(gap);
    base = nvld;
    @(negedge clk); cont_en = 1'b1;
    wait_vld(base + 4);
    g = last_gap;
    check(nvld == base + 4, "R8 frames without start", nvld - base, 4);
    for (int i = 0; i < 4; i++)
      check(int'(res_log[(base + i) % 8]) == int'($signed(pat[i])), "R8 stream word",
            int'(res_log[(base + i) % 8]), int'($signed(pat[i])));
    check(g >= geff + 1 && g <= geff + 2, "R8 gap length", g, geff + 1);
    check(g >= geff, "R6 gap at least max(gap_len, ACQ_MIN)", g, geff);
    cont_en = 1'b0;
    wait_cs_high();
    wait_cycles(200);
  endtask

  // ---------------- main and watchdog ----------------
  initial begin
    checks = 0; errors = 0;
    t_reset();
    t_single(16'h7FFF, 20);
    t_single(16'h8000, 10);
    t_single(16'h0000, 2);     // clamped low; line high before edge 2 (R3)
    t_single(16'hA5C3, 255);   // clamped high
    t_ignore_and_pend();
    t_continuous(100);
    t_continuous(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule